// File: doc/BRIEF.md
# Amplifier Protection Fault Manager

This block turns the protection flags of a two-channel switching power amplifier into one shutdown and restart control. All flags arrive already synchronized to the block clock: over-temperature, supply too low, supply too high, supply unbalance, current limiting active, hard load short, and output window check failure. A 1 ms tick paces every timed policy, and a strobe marks each standby-to-mute transition, when the output window check must be evaluated.

Each fault class has its own policy. Supply and thermal faults force an immediate shutdown, and restart is allowed only after a fixed cool-down that begins when every such flag has cleared. A hard short causes a hiccup: the amplifier stops, waits a fixed time, retries, and repeats while the short persists. Current limiting alone leaves the outputs switching unless it lasts longer than a qualification time, which is then treated like a short. A failed window check holds start-up off until the failure clears, both at start-up and at the end of each hiccup. The start-up sequencer sees one hold signal, a one-cycle restart pulse, and a latched code for the cause of the last shutdown.

The controller is a five-state machine. RUN means the amplifier may switch. SHUTDOWN waits for the thermal and supply flags to clear. COOLDOWN counts the restart delay after they clear. HICCUP counts the retry delay after a short or a current-limit timeout. WINDOW_HOLD waits for the window failure to clear. Transitions: RUN→SHUTDOWN, COOLDOWN→SHUTDOWN, HICCUP→SHUTDOWN and WINDOW_HOLD→SHUTDOWN on any thermal or supply flag. SHUTDOWN→COOLDOWN when all of those flags are low. COOLDOWN→RUN when the delay expires. RUN→HICCUP on a short or a current-limit timeout. HICCUP→RUN when the delay expires with the window good. HICCUP→WINDOW_HOLD when the delay expires with the window bad. RUN→WINDOW_HOLD on the check strobe with the window bad. WINDOW_HOLD→RUN when the window is good.

Top module: `amp_fault_mgr`

## Requirements
- R1: After reset, fault_hold, restart_pulse, ilim_status and fault_cause are all 0.
- R2: While running, a high over_temp, supply_high, supply_low or supply_skew asserts fault_hold one clock later and latches fault_cause 1, 2, 3 or 4 respectively.
- R3: After every thermal and supply flag is low, fault_hold releases only after RESTART_MS further ticks (default 100). A thermal or supply flag that rises during this countdown returns to shutdown, updates fault_cause, and the full count starts again after it clears.
- R4: ilim_status equals ilim_active while running, and outputs keep switching. When ilim_active stays high for OCP_TAU_MS ticks (default 20), fault_hold asserts with fault_cause 6 and a hiccup follows.
- R5: If ilim_active drops for at least one cycle before the qualification time expires, the count restarts from zero, so short bursts of current limiting never cause a shutdown.
- R6: A high load_short while running asserts fault_hold one clock later with fault_cause 5. A retry follows after RESTART_MS ticks, and a short that persists produces one retry each RESTART_MS ticks.
- R7: window_bad is sampled only while running on a cycle with startup_check high. A failure there holds start-up (fault_cause 7) until window_bad goes low. window_bad without the strobe has no effect.
- R8: At the end of a hiccup the window is checked again. If window_bad is high, the block enters the window hold with fault_cause 7 instead of restarting.
- R9: When several causes arise together, fault_cause takes the highest-priority one. The order from highest to lowest is: over_temp 1, supply_high 2, supply_low 3, supply_skew 4, load_short 5, current-limit timeout 6, window 7.
- R10: restart_pulse is high for exactly one cycle, on the first cycle that fault_hold is low after a hold.
- R11: fault_cause keeps its value after the hold releases and changes only when a new shutdown begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| startup_check | input | 1 | Strobe on a standby-to-mute transition |
| over_temp | input | 1 | Junction over-temperature flag |
| supply_low | input | 1 | Supply under-voltage flag |
| supply_high | input | 1 | Supply over-voltage flag |
| supply_skew | input | 1 | Positive/negative supply unbalance flag |
| ilim_active | input | 1 | Output current limiting in progress |
| load_short | input | 1 | Load impedance below short threshold |
| window_bad | input | 1 | Output window check failing |
| fault_hold | output | 1 | Holds the start-up sequencer off |
| ilim_status | output | 1 | Current limiting while running |
| fault_cause | output | 3 | Latched cause of the last shutdown |
| restart_pulse | output | 1 | One-cycle pulse when the hold releases |

## Verification
The checker asserts four properties on every cycle: a thermal or supply flag is followed by a hold, the restart pulse is single and coincides with the hold falling, the cause code is stable while running, and the current-limit status is never reported during a hold. Only the bench scenarios can show the timed behaviour: the exact tick counts of the cool-down, hiccup and current-limit qualification, the count restarting after a brief drop in limiting, repeated hiccups on a persistent short, the window re-check, and the cause priority order.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SHUTDOWN,
        ST_COOLDOWN,
        ST_HICCUP,
        ST_WINDOW_HOLD
    } mgr_state_t;

    // request vector bit order is priority order, bit 0 highest
    localparam int NUM_CAUSES = 7;
    localparam int CAUSE_W    = $clog2(NUM_CAUSES + 1);

    localparam int REQ_TEMP   = 0;
    localparam int REQ_HIGH   = 1;
    localparam int REQ_LOW    = 2;
    localparam int REQ_SKEW   = 3;
    localparam int REQ_SHORT  = 4;
    localparam int REQ_OCP    = 5;
    localparam int REQ_WINDOW = 6;

endpackage

// File: rtl/ms_delay_timer.sv
module ms_delay_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_zero,
    input  logic tick_ms,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hold_zero)
            cnt_q <= '0;
        else if (tick_ms && cnt_q != CW'(LIMIT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/ilim_qualifier.sv
module ilim_qualifier #(
    parameter int TAU_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim_active,
    input  logic running,
    input  logic tick_ms,
    output logic trip
);
    localparam int CW = $clog2(TAU_MS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!ilim_active || !running)
            cnt_q <= '0;
        else if (tick_ms && cnt_q != CW'(TAU_MS))
            cnt_q <= cnt_q + 1'b1;
    end

    assign trip = ilim_active && (cnt_q == CW'(TAU_MS));
endmodule

// File: rtl/fault_prio_enc.sv
module fault_prio_enc #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                code = W'(i + 1);
        end
    end
endmodule

// File: rtl/amp_fault_mgr.sv
module amp_fault_mgr
    import amp_fault_pkg::*;
#(
    parameter int RESTART_MS = 100,
    parameter int OCP_TAU_MS = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_ms,
    input  logic               startup_check,
    input  logic               over_temp,
    input  logic               supply_low,
    input  logic               supply_high,
    input  logic               supply_skew,
    input  logic               ilim_active,
    input  logic               load_short,
    input  logic               window_bad,
    output logic               fault_hold,
    output logic               ilim_status,
    output logic [CAUSE_W-1:0] fault_cause,
    output logic               restart_pulse
);
    mgr_state_t           state_q, state_d;
    logic [CAUSE_W-1:0]   cause_q;
    logic                 pulse_q;
    logic                 load_cause;
    logic [NUM_CAUSES-1:0] req_v;
    logic [CAUSE_W-1:0]   req_code;
    logic [3:0]           level_v;
    logic                 level_any;
    logic                 ocp_trip;
    logic                 delay_done;
    logic                 timer_idle;

    assign level_v   = {supply_skew, supply_low, supply_high, over_temp};
    assign level_any = |level_v;
    assign timer_idle = !(state_q == ST_COOLDOWN || state_q == ST_HICCUP);

    ms_delay_timer #(.LIMIT(RESTART_MS)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (timer_idle),
        .tick_ms   (tick_ms),
        .expired   (delay_done)
    );

    ilim_qualifier #(.TAU_MS(OCP_TAU_MS)) u_ilim (
        .clk         (clk),
        .rst_n       (rst_n),
        .ilim_active (ilim_active),
        .running     (state_q == ST_RUN),
        .tick_ms     (tick_ms),
        .trip        (ocp_trip)
    );

    fault_prio_enc #(.N(NUM_CAUSES), .W(CAUSE_W)) u_enc (
        .req  (req_v),
        .code (req_code)
    );

    // next-state and cause selection
    always_comb begin
        state_d    = state_q;
        load_cause = 1'b0;
        req_v      = {3'b000, level_v};
        unique case (state_q)
            ST_RUN: begin
                req_v = {startup_check & window_bad, ocp_trip, load_short, level_v};
                load_cause = |req_v;
                if (level_any)
                    state_d = ST_SHUTDOWN;
                else if (load_short || ocp_trip)
                    state_d = ST_HICCUP;
                else if (startup_check && window_bad)
                    state_d = ST_WINDOW_HOLD;
            end
            ST_SHUTDOWN: begin
                if (!level_any)
                    state_d = ST_COOLDOWN;
            end
            ST_COOLDOWN: begin
                if (level_any) begin
                    state_d    = ST_SHUTDOWN;
                    load_cause = 1'b1;
                end else if (delay_done) begin
                    state_d = ST_RUN;
                end
            end
            ST_HICCUP: begin
                if (level_any) begin
                    state_d    = ST_SHUTDOWN;
                    load_cause = 1'b1;
                end else if (delay_done) begin
                    if (window_bad) begin
                        state_d    = ST_WINDOW_HOLD;
                        req_v      = 7'b100_0000;
                        load_cause = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_WINDOW_HOLD: begin
                if (level_any) begin
                    state_d    = ST_SHUTDOWN;
                    load_cause = 1'b1;
                end else if (!window_bad) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_cause)
                cause_q <= req_code;
            pulse_q <= (state_q != ST_RUN) && (state_d == ST_RUN);
        end
    end

    // outputs
    always_comb begin
        fault_hold    = (state_q != ST_RUN);
        ilim_status   = ilim_active && (state_q == ST_RUN);
        fault_cause   = cause_q;
        restart_pulse = pulse_q;
    end
endmodule

// File: rtl/amp_fault_mgr_chk.sv
module amp_fault_mgr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       over_temp,
    input logic       supply_low,
    input logic       supply_high,
    input logic       supply_skew,
    input logic       fault_hold,
    input logic       ilim_status,
    input logic [2:0] fault_cause,
    input logic       restart_pulse
);
    assert_level_fault_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp || supply_low || supply_high || supply_skew) |=> fault_hold);

    assert_pulse_at_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> (!fault_hold && $past(fault_hold)));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse);

    assert_cause_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_hold |-> $stable(fault_cause));

    assert_ilim_only_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_status |-> !fault_hold);
endmodule

bind amp_fault_mgr amp_fault_mgr_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .over_temp     (over_temp),
    .supply_low    (supply_low),
    .supply_high   (supply_high),
    .supply_skew   (supply_skew),
    .fault_hold    (fault_hold),
    .ilim_status   (ilim_status),
    .fault_cause   (fault_cause),
    .restart_pulse (restart_pulse)
);

// File: tb/amp_fault_mgr_bench.sv
module amp_fault_mgr_bench;
    localparam int RESTART = 100;
    localparam int TAU     = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 0, startup_check = 0, over_temp = 0, supply_low = 0;
    logic supply_high = 0, supply_skew = 0, ilim_active = 0, load_short = 0, window_bad = 0;
    logic fault_hold, ilim_status, restart_pulse;
    logic [2:0] fault_cause;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    amp_fault_mgr #(.RESTART_MS(RESTART), .OCP_TAU_MS(TAU)) u_amp_fault_mgr (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .startup_check(startup_check),
        .over_temp(over_temp), .supply_low(supply_low), .supply_high(supply_high),
        .supply_skew(supply_skew), .ilim_active(ilim_active), .load_short(load_short),
        .window_bad(window_bad), .fault_hold(fault_hold), .ilim_status(ilim_status),
        .fault_cause(fault_cause), .restart_pulse(restart_pulse)
    );

    always @(negedge clk) if (rst_n && restart_pulse) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic test_reset_R1();
        chk("R1 hold", fault_hold, 0);
        chk("R1 cause", fault_cause, 0);
        chk("R1 pulse", restart_pulse, 0);
        chk("R1 ilim_status", ilim_status, 0);
    endtask

    task automatic test_level_R2_R3_R11();
        int p0;
        over_temp = 1; cyc(1);
        chk("R2 hold on temp", fault_hold, 1);
        chk("R2 cause temp", fault_cause, 1);
        cyc(30);
        over_temp = 0; cyc(1);
        p0 = pulses;
        ticks(RESTART - 1);
        chk("R3 still held at count-1", fault_hold, 1);
        ticks(1); cyc(2);
        chk("R3 released", fault_hold, 0);
        chk("R10 one pulse", pulses - p0, 1);
        chk("R11 cause kept", fault_cause, 1);
        supply_high = 1; cyc(1);
        chk("R2 cause high", fault_cause, 2);
        supply_high = 0; cyc(1);
        ticks(50);
        supply_low = 1; cyc(1);
        chk("R3 refault cause low", fault_cause, 3);
        supply_low = 0; cyc(1);
        ticks(RESTART - 1);
        chk("R3 full recount", fault_hold, 1);
        ticks(1); cyc(2);
        chk("R3 released after recount", fault_hold, 0);
        supply_skew = 1; cyc(1);
        chk("R2 cause skew", fault_cause, 4);
        supply_skew = 0; cyc(1); ticks(RESTART); cyc(2);
        chk("R3 release skew", fault_hold, 0);
    endtask

    task automatic test_ilim_R4_R5();
        ilim_active = 1; cyc(1);
        chk("R4 status follows", ilim_status, 1);
        ticks(TAU - 5);
        ilim_active = 0; cyc(1);
        chk("R4 status drops", ilim_status, 0);
        ilim_active = 1;
        ticks(TAU - 1); cyc(2);
        chk("R5 count restarted, no hold", fault_hold, 0);
        ticks(1); cyc(2);
        chk("R4 timeout hold", fault_hold, 1);
        chk("R4 cause timeout", fault_cause, 6);
        chk("R4 status off in hold", ilim_status, 0);
        ilim_active = 0;
        ticks(RESTART); cyc(2);
        chk("R4 hiccup restart", fault_hold, 0);
    endtask

    task automatic test_short_R6();
        int p0;
        p0 = pulses;
        load_short = 1; cyc(1);
        chk("R6 hold on short", fault_hold, 1);
        chk("R6 cause short", fault_cause, 5);
        ticks(RESTART); cyc(1);
        ticks(RESTART); cyc(1);
        chk("R6 repeated retries", pulses - p0, 2);
        chk("R6 held while short", fault_hold, 1);
        load_short = 0;
        ticks(RESTART); cyc(2);
        chk("R6 released", fault_hold, 0);
    endtask

    task automatic test_window_R7_R8();
        window_bad = 1; cyc(5);
        chk("R7 ignored without strobe", fault_hold, 0);
        startup_check = 1; cyc(1); startup_check = 0;
        chk("R7 window hold", fault_hold, 1);
        chk("R7 cause window", fault_cause, 7);
        ticks(RESTART + 20);
        chk("R7 held indefinitely", fault_hold, 1);
        window_bad = 0; cyc(2);
        chk("R7 released on clear", fault_hold, 0);
        load_short = 1; cyc(1);
        load_short = 0; window_bad = 1;
        ticks(RESTART); cyc(2);
        chk("R8 recheck holds", fault_hold, 1);
        chk("R8 cause window", fault_cause, 7);
        window_bad = 0; cyc(2);
        chk("R8 released", fault_hold, 0);
    endtask

    task automatic test_priority_R9();
        supply_low = 1; supply_skew = 1; supply_high = 1; load_short = 1; cyc(1);
        chk("R9 high wins", fault_cause, 2);
        supply_low = 0; supply_skew = 0; supply_high = 0; load_short = 0;
        cyc(1); ticks(RESTART); cyc(2);
        over_temp = 1; supply_high = 1; load_short = 1; cyc(1);
        chk("R9 temp wins", fault_cause, 1);
        over_temp = 0; supply_high = 0; load_short = 0;
        cyc(1); ticks(RESTART); cyc(2);
        supply_skew = 1; supply_low = 1; cyc(1);
        chk("R9 low over skew", fault_cause, 3);
        supply_skew = 0; supply_low = 0;
        cyc(1); ticks(RESTART); cyc(2);
        chk("R9 final release", fault_hold, 0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        test_reset_R1();
        rst_n = 1'b1;
        cyc(2);
        test_reset_R1();
        test_level_R2_R3_R11();
        test_ilim_R4_R5();
        test_short_R6();
        test_window_R7_R8();
        test_priority_R9();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule